// File: doc/BRIEF.md
# Timer Status Flags and Software Event Strobes

This block keeps the sticky status flags of a general-purpose timer with four capture/compare channels. It also decodes the write-only event register through which software forces those events. It sits beside the counter and channel logic and takes their one-cycle pulses: compare hits, capture edges, counter wrap in either direction, trigger pulses and trigger-driven counter restarts. It turns these into flags that stay set until software clears them. Each channel flag picks its hardware source from the channel direction. An output channel listens to compare hits. An input channel listens to capture edges, and software reading the captured value also clears the flag.

The update flag is gated by two control bits. The disable bit blocks every update source. The source-select bit limits the update flag to counter wrap, so software-forced and trigger-driven restarts no longer set it. Software clears a status flag by writing 0 to its bit; writing 1 leaves the bit alone. Writing 1 to an event-register bit fires the matching event in that same cycle. The event register holds no state, so each bit clears itself. Interrupt requests are the level AND of each flag with its enable.

Status and event registers share one bit layout. Bit 0 is the update flag, bits 1 to 4 are channels 1 to 4, bit 5 is reserved and bit 6 is the trigger flag. Bits 15:7 are reserved.

Top module: `tmr_evt_flags`

## Requirements
- R1: After reset, `stat_rdata` reads 0x0000, `irq` is all zero and `ug_req` is 0.
- R2: A channel in output mode (`ch_out_mode`=1) sets its status bit (bit 1+i for channel i) in the cycle after `cmp_hit`; in output mode `cap_edge` has no effect on the flag.
- R3: A channel in input mode (`ch_out_mode`=0) sets its status bit in the cycle after `cap_edge`; in input mode `cmp_hit` has no effect on the flag.
- R4: In input mode a `ccv_rd` pulse clears that channel's flag in the next cycle; in output mode `ccv_rd` leaves the flag unchanged.
- R5: A write with `reg_addr`=0 (status) clears each flag whose `reg_wdata` bit is 0 and leaves each flag whose bit is 1 unchanged; with no clearing event a flag holds its value.
- R6: When a hardware or software set and a clear reach the same flag in one cycle, the flag ends up set.
- R7: `cnt_ovf` or `cnt_unf` sets the update flag (bit 0) in the next cycle only when `upd_dis`=0.
- R8: A write with `reg_addr`=1 and `reg_wdata[0]`=1, or a `trg_reinit` pulse, sets the update flag only when `upd_dis`=0 and `upd_src_sel`=0. The same write always drives `ug_req` high in that cycle.
- R9: With `reg_addr`=1, a 1 in `reg_wdata` bits 1 to 4 sets channel flags 1 to 4 and a 1 in bit 6 sets the trigger flag, whatever the channel mode. Zero bits, bit 5 and bits 15:7 have no effect, and the register holds nothing between writes.
- R10: A `trg_pulse` sets the trigger flag (status bit 6) in the next cycle.
- R11: `irq[k]` is high exactly while status bit k and `irq_en[k]` are both 1, and stays high for as long as both stay set.
- R12: Status bits 5 and 15:7 always read 0, whatever is written to either register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 selects status, 1 selects event register |
| reg_wdata | input | 16 | Write data |
| stat_rdata | output | 16 | Status register value |
| ch_out_mode | input | 4 | Per channel: 1 output (compare), 0 input (capture) |
| cmp_hit | input | 4 | Per-channel compare-match pulse |
| cap_edge | input | 4 | Per-channel capture-edge pulse |
| ccv_rd | input | 4 | Per-channel pulse: software read of the captured value |
| cnt_ovf | input | 1 | Counter overflow pulse |
| cnt_unf | input | 1 | Counter underflow pulse |
| trg_reinit | input | 1 | Counter restarted by a trigger |
| trg_pulse | input | 1 | Trigger event pulse |
| upd_dis | input | 1 | Update disable |
| upd_src_sel | input | 1 | 1: only wrap sets the update flag |
| irq_en | input | 7 | Per-flag interrupt enable, status bit layout |
| irq | output | 7 | Interrupt requests, status bit layout |
| ug_req | output | 1 | Software counter-restart request, same cycle as the write |

## Verification
The assertions assume that event inputs are single-cycle pulses sampled at the clock edge. They also assume that `ch_out_mode`, `upd_dis` and `upd_src_sel` are valid in the same cycle as the pulses they qualify, so any mix of these may arrive together. The stimulus draws every input afresh each cycle from a seeded generator. It makes status clears sparse so that flags persist, and it lets modes and gate bits change every cycle, so that set, clear and gating conditions collide in all combinations. Directed steps come first and cover each gate and each reserved bit on its own.

// File: rtl/tmr_evt_pkg.sv
package tmr_evt_pkg;
  localparam int unsigned REG_W     = 16;
  localparam bit          ADDR_STAT = 1'b0;
  localparam bit          ADDR_EGEN = 1'b1;

  // Hardware source of a channel flag, chosen by direction, plus forced event.
  function automatic logic chan_set(input logic out_mode, input logic cmp,
                                    input logic cap, input logic gen);
    return (out_mode ? cmp : cap) | gen;
  endfunction

  // Update flag set condition with its two gating bits.
  function automatic logic upd_set(input logic ovf, input logic unf,
                                   input logic sw_restart, input logic trg_restart,
                                   input logic dis, input logic wrap_only);
    logic wrap, restart;
    wrap    = ovf | unf;
    restart = sw_restart | trg_restart;
    return !dis && (wrap || (!wrap_only && restart));
  endfunction

  // Sticky flag: set dominates clear.
  function automatic logic sticky_next(input logic cur, input logic set,
                                       input logic clr);
    return set | (cur & ~clr);
  endfunction
endpackage

// File: rtl/tmr_evgen.sv
module tmr_evgen
  import tmr_evt_pkg::*;
#(
  parameter int unsigned NCH = 4
) (
  input  logic             reg_wr,
  input  logic             reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic             ug_w,
  output logic [NCH-1:0]   ccg_w,
  output logic             tg_w,
  output logic [NCH+2:0]   sw_clr
);
  localparam int unsigned FW     = NCH + 3;
  localparam int unsigned TG_BIT = NCH + 2;
  localparam int unsigned RS_BIT = NCH + 1;

  logic sel_stat, sel_gen;
  logic unused_wbits;

  assign sel_stat = reg_wr && (reg_addr == ADDR_STAT);
  assign sel_gen  = reg_wr && (reg_addr == ADDR_EGEN);

  // Status write: a 0 bit requests a clear, a 1 bit leaves the flag.
  assign sw_clr = sel_stat ? ~reg_wdata[FW-1:0] : '0;

  // Event register: pure strobes, nothing is stored.
  assign ug_w  = sel_gen & reg_wdata[0];
  assign ccg_w = sel_gen ? reg_wdata[NCH:1] : '0;
  assign tg_w  = sel_gen & reg_wdata[TG_BIT];

  assign unused_wbits = ^{reg_wdata[REG_W-1:FW], reg_wdata[RS_BIT]};
endmodule

// File: rtl/tmr_chan_flag.sv
module tmr_chan_flag
  import tmr_evt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic out_mode,
  input  logic cmp_hit,
  input  logic cap_edge,
  input  logic ccv_rd,
  input  logic gen,
  input  logic sw_clr,
  output logic flag_q
);
  logic set_w, rd_clr_w, clr_w;

  assign set_w    = chan_set(out_mode, cmp_hit, cap_edge, gen);
  assign rd_clr_w = !out_mode && ccv_rd;
  assign clr_w    = sw_clr | rd_clr_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= sticky_next(flag_q, set_w, clr_w);
  end

  // R2
  out_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_mode && cmp_hit) |=> flag_q);
  // R3
  in_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_mode && cap_edge) |=> flag_q);
  // R4
  rd_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_mode && ccv_rd && !cap_edge && !gen) |=> !flag_q);
  // R5
  chan_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !sw_clr && (out_mode || !ccv_rd)) |=> flag_q);
endmodule

// File: rtl/tmr_upd_flag.sv
module tmr_upd_flag
  import tmr_evt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cnt_ovf,
  input  logic cnt_unf,
  input  logic ug,
  input  logic trg_reinit,
  input  logic upd_dis,
  input  logic upd_src_sel,
  input  logic sw_clr,
  output logic flag_q
);
  logic set_w;

  assign set_w = upd_set(cnt_ovf, cnt_unf, ug, trg_reinit, upd_dis, upd_src_sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= sticky_next(flag_q, set_w, sw_clr);
  end

  // R7
  wrap_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_dis && (cnt_ovf || cnt_unf)) |=> flag_q);
  // R8
  upd_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_q && (upd_dis || (upd_src_sel && !cnt_ovf && !cnt_unf))) |=> !flag_q);
  // R5
  upd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !sw_clr) |=> flag_q);
endmodule

// File: rtl/tmr_evt_flags.sv
module tmr_evt_flags
  import tmr_evt_pkg::*;
#(
  parameter int unsigned NCH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] stat_rdata,
  input  logic [NCH-1:0]   ch_out_mode,
  input  logic [NCH-1:0]   cmp_hit,
  input  logic [NCH-1:0]   cap_edge,
  input  logic [NCH-1:0]   ccv_rd,
  input  logic             cnt_ovf,
  input  logic             cnt_unf,
  input  logic             trg_reinit,
  input  logic             trg_pulse,
  input  logic             upd_dis,
  input  logic             upd_src_sel,
  input  logic [NCH+2:0]   irq_en,
  output logic [NCH+2:0]   irq,
  output logic             ug_req
);
  localparam int unsigned FW     = NCH + 3;
  localparam int unsigned TG_BIT = NCH + 2;
  localparam int unsigned RS_BIT = NCH + 1;

  logic           ug_w, tg_w, upd_flag, trg_flag;
  logic [NCH-1:0] ccg_w, ch_flag;
  logic [FW-1:0]  sw_clr, flags_w;
  logic           unused_rsv_clr;

  tmr_evgen #(.NCH(NCH)) u_gen (
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .ug_w      (ug_w),
    .ccg_w     (ccg_w),
    .tg_w      (tg_w),
    .sw_clr    (sw_clr)
  );

  tmr_upd_flag u_upd (
    .clk         (clk),
    .rst_n       (rst_n),
    .cnt_ovf     (cnt_ovf),
    .cnt_unf     (cnt_unf),
    .ug          (ug_w),
    .trg_reinit  (trg_reinit),
    .upd_dis     (upd_dis),
    .upd_src_sel (upd_src_sel),
    .sw_clr      (sw_clr[0]),
    .flag_q      (upd_flag)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    tmr_chan_flag u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .out_mode (ch_out_mode[i]),
      .cmp_hit  (cmp_hit[i]),
      .cap_edge (cap_edge[i]),
      .ccv_rd   (ccv_rd[i]),
      .gen      (ccg_w[i]),
      .sw_clr   (sw_clr[i+1]),
      .flag_q   (ch_flag[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trg_flag <= 1'b0;
    else        trg_flag <= sticky_next(trg_flag, trg_pulse | tg_w, sw_clr[TG_BIT]);
  end

  assign unused_rsv_clr = sw_clr[RS_BIT];
  assign flags_w    = {trg_flag, 1'b0, ch_flag, upd_flag};
  assign stat_rdata = {{(REG_W-FW){1'b0}}, flags_w};
  assign irq        = flags_w & irq_en;
  assign ug_req     = ug_w;

  // R10
  trig_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trg_pulse |=> stat_rdata[TG_BIT]);
  // R9
  tg_gen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr && reg_wdata[TG_BIT]) |=> stat_rdata[TG_BIT]);
  // R6
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trg_pulse && reg_wr && !reg_addr && !reg_wdata[TG_BIT]) |=> stat_rdata[TG_BIT]);
endmodule

// File: tb/sim_tmr_evt_flags.sv
`timescale 1ns/1ps
module sim_tmr_evt_flags;
  localparam int NCH = 4;
  localparam int FW  = NCH + 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic           reg_wr, reg_addr;
  logic [15:0]    reg_wdata, stat_rdata;
  logic [NCH-1:0] ch_out_mode, cmp_hit, cap_edge, ccv_rd;
  logic           cnt_ovf, cnt_unf, trg_reinit, trg_pulse, upd_dis, upd_src_sel;
  logic [FW-1:0]  irq_en, irq;
  logic           ug_req;

  tmr_evt_flags #(.NCH(NCH)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .stat_rdata(stat_rdata), .ch_out_mode(ch_out_mode),
    .cmp_hit(cmp_hit), .cap_edge(cap_edge), .ccv_rd(ccv_rd), .cnt_ovf(cnt_ovf),
    .cnt_unf(cnt_unf), .trg_reinit(trg_reinit), .trg_pulse(trg_pulse),
    .upd_dis(upd_dis), .upd_src_sel(upd_src_sel), .irq_en(irq_en), .irq(irq),
    .ug_req(ug_req)
  );

  int nvec = 0;
  int nbad = 0;
  bit done = 1'b0;
  logic [FW-1:0] exp_st;

  // Expected next flags from the requirements (layout: 0 upd, 1..4 ch, 6 trig).
  function automatic logic [FW-1:0] model_next(input logic [FW-1:0] cur);
    logic [FW-1:0] n, clr, ev;
    logic hs, s, c;
    clr = (reg_wr && reg_addr == 1'b0) ? ~reg_wdata[FW-1:0] : '0;
    ev  = (reg_wr && reg_addr == 1'b1) ? reg_wdata[FW-1:0] : '0;
    for (int i = 0; i < NCH; i++) begin
      hs = ch_out_mode[i] ? cmp_hit[i] : cap_edge[i];
      s  = hs || ev[i+1];
      c  = clr[i+1] || (!ch_out_mode[i] && ccv_rd[i]);
      n[i+1] = s ? 1'b1 : (c ? 1'b0 : cur[i+1]);
    end
    s = (!upd_dis && (cnt_ovf || cnt_unf)) ||
        (!upd_dis && !upd_src_sel && (ev[0] || trg_reinit));
    n[0] = s ? 1'b1 : (clr[0] ? 1'b0 : cur[0]);
    s = trg_pulse || ev[6];
    n[6] = s ? 1'b1 : (clr[6] ? 1'b0 : cur[6]);
    n[5] = 1'b0;
    return n;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
    nvec++;
    if (act !== expv) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic idle();
    reg_wr = 0; reg_addr = 0; reg_wdata = '0; cmp_hit = '0; cap_edge = '0;
    ccv_rd = '0; cnt_ovf = 0; cnt_unf = 0; trg_reinit = 0; trg_pulse = 0;
  endtask

  task automatic tick();
    logic [FW-1:0] nx;
    nx = model_next(exp_st);
    @(posedge clk);
    @(negedge clk);
    exp_st = nx;
    idle();
  endtask

  task automatic chk_out(input string tag);
    chk(tag, {16'h0, stat_rdata}, {25'h0, exp_st});
    chk(tag, {25'h0, irq}, {25'h0, exp_st & irq_en});
  endtask

  task automatic wr(input logic a, input logic [15:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
  endtask

  initial begin
    #(500_000);
    if (!done) begin
      nbad++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    idle();
    ch_out_mode = 4'b0011; upd_dis = 0; upd_src_sel = 0; irq_en = '1;
    exp_st = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk_out("R1 reset state");
    chk("R1 ug_req idle", {31'h0, ug_req}, 32'h0);

    // R2: output mode compare sets; capture ignored
    cmp_hit[0] = 1; cap_edge[1] = 1; tick();
    chk_out("R2 compare in output mode");
    // R3: input mode capture sets; compare ignored
    cap_edge[2] = 1; cmp_hit[3] = 1; tick();
    chk_out("R3 capture in input mode");
    // R4: read clears input channel only
    ccv_rd[2] = 1; ccv_rd[0] = 1; tick();
    chk_out("R4 read clear");
    // R5: write 0 clears, 1 keeps
    wr(0, 16'hFFFF); tick();
    chk_out("R5 write ones keeps");
    wr(0, 16'hFFFD); tick();
    chk_out("R5 write zero clears");
    // R6: set beats clear
    cmp_hit[0] = 1; wr(0, 16'h0000); tick();
    chk_out("R6 set wins");
    wr(0, 16'h0); tick();
    // R7: wrap sets only when enabled
    cnt_ovf = 1; tick();
    chk_out("R7 overflow sets");
    wr(0, 16'h0); tick();
    upd_dis = 1; cnt_unf = 1; tick();
    chk_out("R7 underflow blocked");
    upd_dis = 0; cnt_unf = 1; tick();
    chk_out("R7 underflow sets");
    wr(0, 16'h0); tick();
    // R8: restart gating
    upd_src_sel = 1; wr(1, 16'h0001); #1;
    chk("R8 ug_req strobe", {31'h0, ug_req}, 32'h1);
    tick();
    chk_out("R8 restart blocked by source select");
    upd_src_sel = 0; trg_reinit = 1; tick();
    chk_out("R8 trigger restart sets");
    wr(0, 16'h0); tick();
    upd_dis = 1; wr(1, 16'h0001); tick();
    chk_out("R8 restart blocked by disable");
    upd_dis = 0; wr(1, 16'h0001); tick();
    chk_out("R8 software restart sets");
    wr(0, 16'h0); tick();
    // R9: event register
    wr(1, 16'hFFA0); tick();
    chk_out("R9 reserved event bits ignored");
    wr(1, 16'h0000); tick();
    chk_out("R9 zero write no effect");
    wr(1, 16'h005E); tick();
    chk_out("R9 channel and trigger generation");
    tick();
    chk_out("R9 nothing stored");
    wr(0, 16'h0); tick();
    // R10
    trg_pulse = 1; tick();
    chk_out("R10 trigger pulse");
    // R11: level interrupts under masks
    irq_en = '0; tick(); chk_out("R11 all masked");
    irq_en = 7'h40; tick(); chk_out("R11 trigger enabled");
    tick(); chk_out("R11 level persists");
    irq_en = '1;
    // R12: reserved status bits
    wr(0, 16'hFFFF); tick(); wr(1, 16'hFFFF); tick();
    chk_out("R12 reserved read zero");

    // Random phase
    for (int k = 0; k < 3000; k++) begin
      ch_out_mode = 4'($urandom);
      upd_dis     = ($urandom % 4) == 0;
      upd_src_sel = ($urandom % 3) == 0;
      irq_en      = 7'($urandom);
      cmp_hit     = 4'($urandom) & 4'($urandom);
      cap_edge    = 4'($urandom) & 4'($urandom);
      ccv_rd      = 4'($urandom) & 4'($urandom) & 4'($urandom);
      cnt_ovf     = ($urandom % 8) == 0;
      cnt_unf     = ($urandom % 8) == 0;
      trg_reinit  = ($urandom % 8) == 0;
      trg_pulse   = ($urandom % 8) == 0;
      if (($urandom % 4) == 0) begin
        reg_wr = 1; reg_addr = 1'($urandom);
        reg_wdata = reg_addr ? (16'($urandom) & 16'($urandom))
                             : (16'($urandom) | 16'($urandom));
      end
      #1;
      chk("R8 ug_req random", {31'h0, ug_req},
          {31'h0, reg_wr && reg_addr && reg_wdata[0]});
      tick();
      chk_out("R2 R3 R4 R5 R6 R7 R9 R10 R11 R12 random");
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule